// File: doc/BRIEF.md
# Program Counter and Address Unit

This block holds the three address registers of a 16-bit single-bus processor: the program counter, the memory address register and the stack pointer. Each clock it receives a 2-bit program-counter command and a 3-bit address-register command from the sequencer. It applies both in the same cycle, using the shared bus value, the page register value and the zero flag as operands.

The program counter can be cleared, loaded from the bus, or loaded from the bus only when the zero flag is set. When no command is given, a fetch strobe advances it by one. The address register can be loaded from the bus, moved up or down by the page register, or returned onto the bus one cycle later. The stack pointer steps by one in its current direction. A mode command turns the direction from counting up to counting down, and the new direction holds until reset. All outputs are registered.

Top module: `pc_addr_unit`

## Requirements
- R1: After a synchronous reset the program counter and address register read 0x0000, the stack pointer reads SP_INIT (default 0x0100), the stack direction is upward and the bus output enable is low with the bus output at 0x0000.
- R2: PC command 2'b01 sets the program counter to 0x0000 on the next clock.
- R3: PC command 2'b10 loads the program counter from the bus input on the next clock.
- R4: PC command 2'b11 loads the program counter from the bus input when the zero flag is 1, and leaves it unchanged when the zero flag is 0.
- R5: With PC command 2'b00 the program counter advances by one, wrapping from 0xFFFF to 0x0000, when the fetch strobe is high, and holds when it is low. Any non-zero PC command takes precedence over the strobe.
- R6: Address command 3'b101 loads the address register from the bus input.
- R7: Address command 3'b001 adds the page value to the address register and 3'b010 subtracts it, both modulo 2^16.
- R8: Address command 3'b110 leaves the address register unchanged. On the next clock it raises the bus output enable and drives the address register value on the bus output. In every other cycle the enable is low and the bus output is 0x0000.
- R9: Address command 3'b100 steps the stack pointer by one in the current direction. No other command changes the stack pointer.
- R10: The direction command makes the stack direction downward. This applies to a step in the same cycle and to every later step, until reset.
- R11: Address commands 3'b000, 3'b011 and 3'b111 leave the address register and the stack pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pc_cmd | input | 2 | Program counter command |
| ma_cmd | input | 3 | Address register / stack command |
| fetch_inc | input | 1 | Fetch strobe, advances the PC when pc_cmd is 00 |
| sp_down | input | 1 | Direction command, makes the stack count downward |
| zero_flag | input | 1 | Zero flag from the ALU |
| bus_in | input | 16 | Value currently on the shared bus |
| page_val | input | 16 | Page register value |
| pc_out | output | 16 | Program counter |
| mem_addr | output | 16 | Memory address register |
| stack_addr | output | 16 | Stack pointer |
| bus_out | output | 16 | Value this block drives onto the bus |
| bus_oe | output | 1 | Bus drive enable |

## Verification
The state that is hardest to reach from the ports is the stack direction. Only the stack pointer's movement reveals it, and only reset clears it. A mode command is therefore issued in the same cycle as a step, to show that the step goes down at once. The next plain step must also go down. After a mid-run reset, a single step has to go up again. Page arithmetic is driven across both ends of the address range so that each wrap shows up in the address register.

// File: rtl/addr_unit_pkg.sv
package addr_unit_pkg;
  typedef enum logic [1:0] {
    PC_KEEP  = 2'b00,
    PC_CLEAR = 2'b01,
    PC_LOAD  = 2'b10,
    PC_LOADZ = 2'b11
  } pc_cmd_e;

  typedef enum logic [2:0] {
    MA_NOP   = 3'b000,
    MA_ADDPG = 3'b001,
    MA_SUBPG = 3'b010,
    MA_STEP  = 3'b100,
    MA_LOAD  = 3'b101,
    MA_READ  = 3'b110
  } ma_cmd_e;
endpackage

// File: rtl/pc_reg.sv
module pc_reg
  import addr_unit_pkg::*;
#(
  parameter int W = 16,
  parameter logic [W-1:0] RESET_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [1:0]   cmd,
  input  logic         inc,
  input  logic         zf,
  input  logic [W-1:0] bus_in,
  output logic [W-1:0] pc_q
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] pc_d;

  always_comb begin
    pc_d = pc_q;
    case (cmd)
      PC_CLEAR: pc_d = RESET_VAL;
      PC_LOAD:  pc_d = bus_in;
      PC_LOADZ: if (zf) pc_d = bus_in;
      default:  if (inc) pc_d = pc_q + ONE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) pc_q <= RESET_VAL;
    else     pc_q <= pc_d;
  end
endmodule

// File: rtl/mar_reg.sv
module mar_reg
  import addr_unit_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [2:0]   cmd,
  input  logic [W-1:0] page,
  input  logic [W-1:0] bus_in,
  output logic [W-1:0] mar_q,
  output logic [W-1:0] drv_q,
  output logic         drv_en_q
);
  logic [W-1:0] mar_d;

  always_comb begin
    mar_d = mar_q;
    case (cmd)
      MA_ADDPG: mar_d = mar_q + page;
      MA_SUBPG: mar_d = mar_q - page;
      MA_LOAD:  mar_d = bus_in;
      default:  mar_d = mar_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mar_q    <= '0;
      drv_q    <= '0;
      drv_en_q <= 1'b0;
    end else begin
      mar_q    <= mar_d;
      drv_en_q <= (cmd == MA_READ);
      drv_q    <= (cmd == MA_READ) ? mar_q : '0;
    end
  end
endmodule

// File: rtl/sp_reg.sv
module sp_reg #(
  parameter int W = 16,
  parameter logic [W-1:0] INIT = W'(16'h0100)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  input  logic         go_down,
  output logic [W-1:0] sp_q
);
  localparam logic [W-1:0] ONE = W'(1);

  logic down_q;
  logic down_now;

  assign down_now = down_q | go_down;

  always_ff @(posedge clk) begin
    if (rst) begin
      sp_q   <= INIT;
      down_q <= 1'b0;
    end else begin
      down_q <= down_now;
      if (step) sp_q <= down_now ? sp_q - ONE : sp_q + ONE;
    end
  end
endmodule

// File: rtl/pc_addr_unit.sv
module pc_addr_unit
  import addr_unit_pkg::*;
#(
  parameter int W = 16,
  parameter logic [W-1:0] SP_INIT = W'(16'h0100)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [1:0]   pc_cmd,
  input  logic [2:0]   ma_cmd,
  input  logic         fetch_inc,
  input  logic         sp_down,
  input  logic         zero_flag,
  input  logic [W-1:0] bus_in,
  input  logic [W-1:0] page_val,
  output logic [W-1:0] pc_out,
  output logic [W-1:0] mem_addr,
  output logic [W-1:0] stack_addr,
  output logic [W-1:0] bus_out,
  output logic         bus_oe
);
  logic sp_step;
  assign sp_step = (ma_cmd == MA_STEP);

  pc_reg #(.W(W), .RESET_VAL('0)) u_pc (
    .clk(clk), .rst(rst), .cmd(pc_cmd), .inc(fetch_inc), .zf(zero_flag),
    .bus_in(bus_in), .pc_q(pc_out)
  );

  mar_reg #(.W(W)) u_mar (
    .clk(clk), .rst(rst), .cmd(ma_cmd), .page(page_val), .bus_in(bus_in),
    .mar_q(mem_addr), .drv_q(bus_out), .drv_en_q(bus_oe)
  );

  sp_reg #(.W(W), .INIT(SP_INIT)) u_sp (
    .clk(clk), .rst(rst), .step(sp_step), .go_down(sp_down), .sp_q(stack_addr)
  );
endmodule

// File: rtl/pc_addr_unit_chk.sv
module pc_addr_unit_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic [1:0]   pc_cmd,
  input logic [2:0]   ma_cmd,
  input logic         zero_flag,
  input logic [W-1:0] bus_in,
  input logic [W-1:0] pc_out,
  input logic [W-1:0] mem_addr,
  input logic [W-1:0] stack_addr,
  input logic [W-1:0] bus_out,
  input logic         bus_oe
);
  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (pc_out == '0 && mem_addr == '0 && !bus_oe)); // R1
  AST_PC_CLEAR: assert property (@(posedge clk) disable iff (rst)
    pc_cmd == 2'b01 |=> pc_out == '0); // R2
  AST_PC_LOAD: assert property (@(posedge clk) disable iff (rst)
    pc_cmd == 2'b10 |=> pc_out == $past(bus_in)); // R3
  AST_PC_COND_HOLD: assert property (@(posedge clk) disable iff (rst)
    (pc_cmd == 2'b11 && !zero_flag) |=> $stable(pc_out)); // R4
  AST_MAR_LOAD: assert property (@(posedge clk) disable iff (rst)
    ma_cmd == 3'b101 |=> mem_addr == $past(bus_in)); // R6
  AST_BUS_DRIVE: assert property (@(posedge clk) disable iff (rst)
    ma_cmd == 3'b110 |=> (bus_oe && bus_out == $past(mem_addr))); // R8
  AST_BUS_QUIET: assert property (@(posedge clk) disable iff (rst)
    ma_cmd != 3'b110 |=> !bus_oe); // R8
  AST_SP_ONLY_STEP: assert property (@(posedge clk) disable iff (rst)
    ma_cmd != 3'b100 |=> $stable(stack_addr)); // R9
  AST_MAR_NOP: assert property (@(posedge clk) disable iff (rst)
    (ma_cmd == 3'b000 || ma_cmd == 3'b011 || ma_cmd == 3'b111) |=> $stable(mem_addr)); // R11
endmodule

bind pc_addr_unit pc_addr_unit_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .pc_cmd(pc_cmd), .ma_cmd(ma_cmd), .zero_flag(zero_flag),
  .bus_in(bus_in), .pc_out(pc_out), .mem_addr(mem_addr), .stack_addr(stack_addr),
  .bus_out(bus_out), .bus_oe(bus_oe)
);

// File: tb/pc_addr_unit_test.sv
module pc_addr_unit_test;
  localparam int W  = 16;
  localparam int VW = 2 + 3 + 3 + 4*W + 1 + 2*W;
  localparam int NV = 16;

  // {pc_cmd, ma_cmd, inc, down, zf, bus, page, exp_pc, exp_mar, exp_sp, exp_oe, exp_bus}
  localparam logic [VW-1:0] VEC [NV] = '{
    {2'b10,3'b101,1'b0,1'b0,1'b0,16'h1234,16'h0000,16'h1234,16'h1234,16'h0100,1'b0,16'h0000}, // R3 R6
    {2'b00,3'b001,1'b1,1'b0,1'b0,16'h0000,16'h0010,16'h1235,16'h1244,16'h0100,1'b0,16'h0000}, // R5 R7
    {2'b11,3'b010,1'b0,1'b0,1'b0,16'hABCD,16'h0044,16'h1235,16'h1200,16'h0100,1'b0,16'h0000}, // R4 R7
    {2'b11,3'b110,1'b0,1'b0,1'b1,16'hABCD,16'h0000,16'hABCD,16'h1200,16'h0100,1'b1,16'h1200}, // R4 R8
    {2'b01,3'b100,1'b1,1'b0,1'b0,16'h0000,16'h0000,16'h0000,16'h1200,16'h0101,1'b0,16'h0000}, // R2 R5 R9
    {2'b00,3'b011,1'b0,1'b0,1'b0,16'h5555,16'h1111,16'h0000,16'h1200,16'h0101,1'b0,16'h0000}, // R5 R11
    {2'b00,3'b111,1'b0,1'b0,1'b0,16'h5555,16'h1111,16'h0000,16'h1200,16'h0101,1'b0,16'h0000}, // R11
    {2'b00,3'b101,1'b0,1'b0,1'b0,16'hFFF0,16'h0000,16'h0000,16'hFFF0,16'h0101,1'b0,16'h0000}, // R6
    {2'b00,3'b001,1'b0,1'b0,1'b0,16'h0000,16'h0020,16'h0000,16'h0010,16'h0101,1'b0,16'h0000}, // R7 wrap up
    {2'b00,3'b010,1'b0,1'b0,1'b0,16'h0000,16'h0030,16'h0000,16'hFFE0,16'h0101,1'b0,16'h0000}, // R7 wrap down
    {2'b00,3'b100,1'b0,1'b1,1'b0,16'h0000,16'h0000,16'h0000,16'hFFE0,16'h0100,1'b0,16'h0000}, // R10 same cycle
    {2'b00,3'b100,1'b0,1'b0,1'b0,16'h0000,16'h0000,16'h0000,16'hFFE0,16'h00FF,1'b0,16'h0000}, // R10 sticky
    {2'b10,3'b000,1'b0,1'b0,1'b0,16'hFFFF,16'h0000,16'hFFFF,16'hFFE0,16'h00FF,1'b0,16'h0000}, // R3 R11
    {2'b00,3'b000,1'b1,1'b0,1'b0,16'h0000,16'h0000,16'h0000,16'hFFE0,16'h00FF,1'b0,16'h0000}, // R5 wrap
    {2'b00,3'b110,1'b0,1'b0,1'b0,16'h0000,16'h0000,16'h0000,16'hFFE0,16'h00FF,1'b1,16'hFFE0}, // R8
    {2'b00,3'b000,1'b0,1'b0,1'b0,16'h0000,16'h0000,16'h0000,16'hFFE0,16'h00FF,1'b0,16'h0000}  // R8 R11
  };

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [1:0]   pc_cmd = '0;
  logic [2:0]   ma_cmd = '0;
  logic         fetch_inc = 1'b0, sp_down = 1'b0, zero_flag = 1'b0;
  logic [W-1:0] bus_in = '0, page_val = '0;
  logic [W-1:0] pc_out, mem_addr, stack_addr, bus_out;
  logic         bus_oe;
  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  pc_addr_unit uut (
    .clk(clk), .rst(rst), .pc_cmd(pc_cmd), .ma_cmd(ma_cmd), .fetch_inc(fetch_inc),
    .sp_down(sp_down), .zero_flag(zero_flag), .bus_in(bus_in), .page_val(page_val),
    .pc_out(pc_out), .mem_addr(mem_addr), .stack_addr(stack_addr),
    .bus_out(bus_out), .bus_oe(bus_oe)
  );

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step_cycle();
    @(posedge clk);
    #1;
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog expired (R1)");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    step_cycle();
    step_cycle();
    // R1: reset state
    check("R1 pc", pc_out, 16'h0000);
    check("R1 mar", mem_addr, 16'h0000);
    check("R1 sp", stack_addr, 16'h0100);
    check("R1 oe", {15'b0, bus_oe}, 16'h0000);
    check("R1 bus", bus_out, 16'h0000);
    @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] v;
      v = VEC[i];
      {pc_cmd, ma_cmd, fetch_inc, sp_down, zero_flag, bus_in, page_val} = v[VW-1 -: 8+2*W];
      step_cycle();
      check($sformatf("R2/R3/R4/R5 pc vec%0d", i), pc_out, v[4*W:3*W+1]);
      check($sformatf("R6/R7/R11 mar vec%0d", i), mem_addr, v[3*W:2*W+1]);
      check($sformatf("R9/R10 sp vec%0d", i), stack_addr, v[2*W:W+1]);
      check($sformatf("R8 oe vec%0d", i), {15'b0, bus_oe}, {15'b0, v[W]});
      check($sformatf("R8 bus vec%0d", i), bus_out, v[W-1:0]);
      @(negedge clk);
    end

    // R1 mid-run reset restores upward stack direction
    pc_cmd = 2'b00; ma_cmd = 3'b000; fetch_inc = 1'b0; sp_down = 1'b0;
    rst = 1'b1;
    step_cycle();
    check("R1 pc after reset", pc_out, 16'h0000);
    check("R1 sp after reset", stack_addr, 16'h0100);
    @(negedge clk);
    rst = 1'b0;
    ma_cmd = 3'b100;
    step_cycle();
    check("R1 R9 sp steps up after reset", stack_addr, 16'h0101);
    @(negedge clk);

    // R9 stack wraps downward through zero
    rst = 1'b1; ma_cmd = 3'b000;
    step_cycle();
    @(negedge clk);
    rst = 1'b0; ma_cmd = 3'b100; sp_down = 1'b1;
    for (int k = 0; k < 256; k++) begin
      step_cycle();
      @(negedge clk);
      sp_down = 1'b0;
    end
    check("R9 R10 sp at zero", stack_addr, 16'h0000);
    step_cycle();
    check("R9 sp wrap below zero", stack_addr, 16'hFFFF);
    @(negedge clk);
    ma_cmd = 3'b000;

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule